// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block buffers 9-bit words between a write port and a read port. Each port has its own clock, and the two clocks may be unrelated or tied together. The write side keeps a write pointer and produces the full and almost-full indications. The read side keeps a read pointer, produces the empty and almost-empty indications, and holds an output register. Each pointer reaches the other clock domain as a Gray code through a two-stage synchroniser. Every status output is active-low and is driven from a register in the domain that owns it.

The almost-empty threshold n and the almost-full threshold m are inputs to the block. A separate offset block supplies them and sets both to 7 after reset. The second write-enable pin serves one of two roles. The block captures that role from the level on the pin while reset is held. In the gating role the pin must be high for a write to happen. In the load role a write cycle taken with the pin low is not stored in the memory. Instead it appears as a strobe to the offset block.

Top module: `sfifo_pf`

## Requirements
- R1: While `rst_n` is low, both pointers return to zero. `full_n` and `almost_full_n` read 1, `empty_n` and `almost_empty_n` read 0, and `rd_data` reads 0.
- R2: If `wr_en2_ld` is 1 during reset, the pin is a second write enable. A word is stored only when `wr_en1_n` is 0 and `wr_en2_ld` is 1. With `wr_en2_ld` at 0, no word is stored and `offset_wr` stays 0.
- R3: If `wr_en2_ld` is 0 during reset, the pin is a load control. When `wr_en1_n` and `wr_en2_ld` are both 0, `offset_wr` reads 1 and no word enters the memory. When `wr_en1_n` is 0 and `wr_en2_ld` is 1, a word is stored.
- R4: `full_n` goes to 0 at the write edge that stores the DEPTH-th word. Write requests made while `full_n` is 0 are dropped.
- R5: A read happens only when `rd_en1_n` and `rd_en2_n` are both 0 and `empty_n` is 1. Otherwise `rd_data` keeps its previous value.
- R6: Words leave in the order they were written, with no loss and no duplication. This holds even when a read and a write fall on the same edge.
- R7: `empty_n` goes to 0 at the read edge that takes the last word. With tied clocks, after a write into an empty FIFO, `empty_n` goes to 1 at the third rising edge after the write edge and not earlier.
- R8: `almost_empty_n` is 0 while the read side sees 0 to n words, where n is `ae_offset`. It is 1 from n+1 words upward.
- R9: `almost_full_n` is 0 while the write side sees DEPTH−m words or more, where m is `af_offset`. It is 1 below that level.
- R10: With tied clocks, after a read from a full FIFO, `full_n` goes back to 1 at the third rising edge after the read edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset for both sides |
| wr_en1_n | input | 1 | Active-low write enable |
| wr_en2_ld | input | 1 | Second write enable or load control, role captured during reset |
| wr_data | input | WIDTH | Word to store |
| rd_en1_n | input | 1 | Active-low read enable, first of two |
| rd_en2_n | input | 1 | Active-low read enable, second of two |
| rd_data | output | WIDTH | Output register |
| ae_offset | input | AW | Almost-empty threshold n |
| af_offset | input | AW | Almost-full threshold m |
| empty_n | output | 1 | Low when nothing is stored |
| almost_empty_n | output | 1 | Low when n or fewer words are stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| almost_full_n | output | 1 | Low when DEPTH−m or more words are stored |
| offset_wr | output | 1 | Strobe to the offset block for a load-role write |

## Verification
A read and a write can land on the same clock edge. This is provoked twice. The first time is at a middle fill level, where both must take effect. The second is at the full boundary, where the read is taken and the write is dropped because `full_n` is already low. A queue scoreboard judges both cases. It pushes a word only when `full_n` is high at the write edge and pops a word on every accepted read, so a word that was wrongly stored, or one that was lost, shows up as a data mismatch. The bench also measures how many edges it takes for the freed slot and the new word to reach the opposite flag.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    // Role of the dual-purpose write pin, captured while reset is low
    typedef enum logic {
        ROLE_LOAD = 1'b0,
        ROLE_WEN2 = 1'b1
    } pin_role_e;

    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/sfifo_sync.sv
module sfifo_sync #(
    parameter int W      = 7,
    parameter int STAGES = sfifo_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sfifo_mem.sv
module sfifo_mem #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 9,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells_q[waddr] <= wdata;
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/sfifo_wr.sv
module sfifo_wr #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen1_n,
    input  logic          pin,
    input  logic [AW:0]   rgray_sync,
    input  logic [AW-1:0] af_off,
    output logic [AW-1:0] waddr,
    output logic          mem_we,
    output logic [AW:0]   wgray,
    output logic          full_n,
    output logic          afull_n,
    output logic          ofs_wr
);
    import sfifo_pkg::*;
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full_n;
        logic          afull_n;
    } wst_t;

    wst_t          s_d, s_q;
    pin_role_e     role_q;
    logic          wgo;
    logic [PW-1:0] rbin;
    logic [PW-1:0] level;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b = g;
        for (int i = 1; i < PW; i++) b = b ^ (g >> i);
        return b;
    endfunction

    // Role capture: sampled on the write clock while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) role_q <= pin_role_e'(pin);
    end

    always_comb begin
        s_d       = s_q;
        wgo       = !wen1_n && pin && s_q.full_n;
        s_d.bin   = s_q.bin + PW'(wgo);
        s_d.gray  = s_d.bin ^ (s_d.bin >> 1);
        rbin      = g2b(rgray_sync);
        level     = s_d.bin - rbin;
        s_d.full_n  = (level != PW'(DEPTH));
        s_d.afull_n = (level < (PW'(DEPTH) - {1'b0, af_off}));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.full_n  <= 1'b1;
            s_q.afull_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign waddr   = s_q.bin[AW-1:0];
    assign mem_we  = wgo;
    assign wgray   = s_q.gray;
    assign full_n  = s_q.full_n;
    assign afull_n = s_q.afull_n;
    assign ofs_wr  = rst_n && (role_q == ROLE_LOAD) && !pin && !wen1_n;

    assert_full_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.full_n |=> $stable(s_q.bin));
    assert_load_no_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_wr |=> $stable(s_q.bin));
    assert_full_in_afull_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.full_n |-> !s_q.afull_n);
    assert_wgray_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(s_q.gray ^ $past(s_q.gray)) <= 1);
endmodule

// File: rtl/sfifo_rd.sv
module sfifo_rd #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 9,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ren1_n,
    input  logic             ren2_n,
    input  logic [AW:0]      wgray_sync,
    input  logic [AW-1:0]    ae_off,
    input  logic [WIDTH-1:0] mem_q,
    output logic [AW-1:0]    raddr,
    output logic [AW:0]      rgray,
    output logic             empty_n,
    output logic             aempty_n,
    output logic [WIDTH-1:0] dout
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0]    bin;
        logic [PW-1:0]    gray;
        logic             empty_n;
        logic             aempty_n;
        logic [WIDTH-1:0] dout;
    } rst_t;

    rst_t          s_d, s_q;
    logic          rgo;
    logic [PW-1:0] wbin;
    logic [PW-1:0] level;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b = g;
        for (int i = 1; i < PW; i++) b = b ^ (g >> i);
        return b;
    endfunction

    always_comb begin
        s_d          = s_q;
        rgo          = !ren1_n && !ren2_n && s_q.empty_n;
        s_d.bin      = s_q.bin + PW'(rgo);
        s_d.gray     = s_d.bin ^ (s_d.bin >> 1);
        s_d.dout     = rgo ? mem_q : s_q.dout;
        wbin         = g2b(wgray_sync);
        level        = wbin - s_d.bin;
        s_d.empty_n  = (level != '0);
        s_d.aempty_n = (level > {1'b0, ae_off});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign raddr    = s_q.bin[AW-1:0];
    assign rgray    = s_q.gray;
    assign empty_n  = s_q.empty_n;
    assign aempty_n = s_q.aempty_n;
    assign dout     = s_q.dout;

    assert_empty_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.empty_n |=> $stable(s_q.bin));
    assert_hold_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ren1_n || ren2_n) |=> $stable(dout));
    assert_empty_in_aempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.empty_n |-> !s_q.aempty_n);
    assert_rgray_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(s_q.gray ^ $past(s_q.gray)) <= 1);
endmodule

// File: rtl/sfifo_pf.sv
module sfifo_pf #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             wr_en1_n,
    input  logic             wr_en2_ld,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en1_n,
    input  logic             rd_en2_n,
    output logic [WIDTH-1:0] rd_data,
    input  logic [AW-1:0]    ae_offset,
    input  logic [AW-1:0]    af_offset,
    output logic             empty_n,
    output logic             almost_empty_n,
    output logic             full_n,
    output logic             almost_full_n,
    output logic             offset_wr
);
    logic [AW-1:0]    waddr, raddr;
    logic             mem_we;
    logic [AW:0]      wgray, rgray, wgray_s, rgray_s;
    logic [WIDTH-1:0] mem_q;

    sfifo_wr #(.DEPTH(DEPTH), .AW(AW)) i_wr (
        .clk(wr_clk), .rst_n(rst_n), .wen1_n(wr_en1_n), .pin(wr_en2_ld),
        .rgray_sync(rgray_s), .af_off(af_offset), .waddr(waddr), .mem_we(mem_we),
        .wgray(wgray), .full_n(full_n), .afull_n(almost_full_n), .ofs_wr(offset_wr)
    );

    sfifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) i_mem (
        .wclk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_q)
    );

    sfifo_sync #(.W(AW + 1)) i_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    sfifo_sync #(.W(AW + 1)) i_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    sfifo_rd #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) i_rd (
        .clk(rd_clk), .rst_n(rst_n), .ren1_n(rd_en1_n), .ren2_n(rd_en2_n),
        .wgray_sync(wgray_s), .ae_off(ae_offset), .mem_q(mem_q), .raddr(raddr),
        .rgray(rgray), .empty_n(empty_n), .aempty_n(almost_empty_n), .dout(rd_data)
    );
endmodule

// File: tb/test_sfifo_pf.sv
`timescale 1ns/1ps
module test_sfifo_pf;
    localparam int DEPTH = 64;
    localparam int AW    = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       wr_en1_n = 1'b1, wr_en2_ld = 1'b1, rd_en1_n = 1'b1, rd_en2_n = 1'b1;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic [AW-1:0] ae_offset = 6'd7, af_offset = 6'd7;
    logic empty_n, almost_empty_n, full_n, almost_full_n, offset_wr;

    sfifo_pf #(.DEPTH(DEPTH), .WIDTH(9)) i_sfifo_pf (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n),
        .wr_en2_ld(wr_en2_ld), .wr_data(wr_data), .rd_en1_n(rd_en1_n),
        .rd_en2_n(rd_en2_n), .rd_data(rd_data), .ae_offset(ae_offset),
        .af_offset(af_offset), .empty_n(empty_n), .almost_empty_n(almost_empty_n),
        .full_n(full_n), .almost_full_n(almost_full_n), .offset_wr(offset_wr)
    );

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    logic [8:0] exp_q [$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: called at a falling edge, spans one rising edge
    task automatic step(input logic w1n, input logic pin, input logic [8:0] d,
                        input logic r1n, input logic r2n);
        bit wf, rf;
        logic [8:0] e;
        wf = !w1n && pin && full_n;
        rf = !r1n && !r2n && empty_n;
        wr_en1_n = w1n; wr_en2_ld = pin; wr_data = d;
        rd_en1_n = r1n; rd_en2_n = r2n;
        @(negedge clk);
        if (wf) exp_q.push_back(d);
        if (rf) begin
            // Monitor: compare the produced word with the scoreboard head
            if (exp_q.size() == 0) chk(1'b0, "R6 underflow", rd_data, -1);
            else begin
                e = exp_q.pop_front();
                chk(rd_data == e, "R6 data order", rd_data, e);
            end
        end
    endtask

    task automatic wr(input logic [8:0] d); step(1'b0, 1'b1, d, 1'b1, 1'b1); endtask
    task automatic rd(); step(1'b1, 1'b1, 9'd0, 1'b0, 1'b0); endtask
    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(1'b1, 1'b1, 9'd0, 1'b1, 1'b1);
    endtask

    task automatic do_reset(input logic pin_lvl);
        rst_n = 1'b0; wr_en2_ld = pin_lvl; wr_en1_n = 1'b1;
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; wr_en2_ld = 1'b1;
        exp_q.delete();
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b1);
        chk(empty_n == 1'b0, "R1 empty_n", empty_n, 0);
        chk(almost_empty_n == 1'b0, "R1 almost_empty_n", almost_empty_n, 0);
        chk(full_n == 1'b1, "R1 full_n", full_n, 1);
        chk(almost_full_n == 1'b1, "R1 almost_full_n", almost_full_n, 1);
        chk(rd_data == 9'd0, "R1 rd_data", rd_data, 0);

        // R5: read while empty is ignored
        rd();
        idle(4);
        chk(rd_data == 9'd0, "R5 read on empty", rd_data, 0);
        chk(empty_n == 1'b0, "R5 still empty", empty_n, 0);

        // R2: gating role, second enable low blocks the write
        step(1'b0, 1'b0, 9'h1AA, 1'b1, 1'b1);
        chk(offset_wr == 1'b0, "R2 no offset strobe", offset_wr, 0);
        idle(4);
        chk(empty_n == 1'b0, "R2 blocked write", empty_n, 0);

        // R7: empty release latency
        wr(9'h011);
        idle(2);
        chk(empty_n == 1'b0, "R7 empty_n after 2 edges", empty_n, 0);
        idle(1);
        chk(empty_n == 1'b1, "R7 empty_n after 3 edges", empty_n, 1);
        step(1'b1, 1'b1, 9'd0, 1'b0, 1'b1);
        chk(rd_data == 9'd0, "R5 one enable holds", rd_data, 0);
        rd();
        chk(rd_data == 9'h011, "R5 read taken", rd_data, 9'h011);
        chk(empty_n == 1'b0, "R7 empty at last read", empty_n, 0);

        // R8 with n = 7
        for (int i = 0; i < 7; i++) wr(9'(i + 32));
        idle(4);
        chk(almost_empty_n == 1'b0, "R8 seven words", almost_empty_n, 0);
        chk(empty_n == 1'b1, "R7 not empty", empty_n, 1);
        wr(9'h0EE);
        idle(4);
        chk(almost_empty_n == 1'b1, "R8 eight words", almost_empty_n, 1);
        rd();
        chk(almost_empty_n == 1'b0, "R8 back to seven", almost_empty_n, 0);
        for (int i = 0; i < 7; i++) rd();
        chk(empty_n == 1'b0, "R7 drained", empty_n, 0);
        idle(4);

        // R9 / R4 with m = 7
        for (int i = 0; i < 56; i++) wr(9'(i + 100));
        chk(almost_full_n == 1'b1, "R9 56 words", almost_full_n, 1);
        wr(9'd156);
        chk(almost_full_n == 1'b0, "R9 57 words", almost_full_n, 0);
        for (int i = 0; i < 6; i++) wr(9'(i + 200));
        chk(full_n == 1'b1, "R4 63 words", full_n, 1);
        wr(9'd300);
        chk(full_n == 1'b0, "R4 64 words", full_n, 0);
        wr(9'h1FF);
        wr(9'h1FE);
        // R6: read and write on the same edge at the full boundary
        step(1'b0, 1'b1, 9'h155, 1'b0, 1'b0);
        idle(2);
        chk(full_n == 1'b0, "R10 full_n after 2 edges", full_n, 0);
        idle(1);
        chk(full_n == 1'b1, "R10 full_n after 3 edges", full_n, 1);
        for (int i = 0; i < 63; i++) rd();
        chk(empty_n == 1'b0, "R4 extras dropped", empty_n, 0);
        chk(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);
        idle(4);

        // R6: concurrent read and write mid-level
        for (int i = 0; i < 5; i++) wr(9'(i + 400));
        idle(4);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 9'(i + 450), 1'b0, 1'b0);
        idle(4);
        for (int i = 0; i < 5; i++) rd();
        chk(empty_n == 1'b0, "R6 concurrent drained", empty_n, 0);
        chk(rd_data == 9'd459, "R6 last word", rd_data, 459);

        // R8 / R9 with n = 3, m = 2
        ae_offset = 6'd3; af_offset = 6'd2;
        do_reset(1'b1);
        for (int i = 0; i < 3; i++) wr(9'(i + 1));
        idle(4);
        chk(almost_empty_n == 1'b0, "R8 n=3 three words", almost_empty_n, 0);
        wr(9'd4);
        idle(4);
        chk(almost_empty_n == 1'b1, "R8 n=3 four words", almost_empty_n, 1);
        for (int i = 0; i < 57; i++) wr(9'(i + 5));
        chk(almost_full_n == 1'b1, "R9 m=2 61 words", almost_full_n, 1);
        wr(9'd77);
        chk(almost_full_n == 1'b0, "R9 m=2 62 words", almost_full_n, 0);

        // R3: load role
        ae_offset = 6'd7; af_offset = 6'd7;
        do_reset(1'b0);
        step(1'b0, 1'b0, 9'h0AB, 1'b1, 1'b1);
        chk(offset_wr == 1'b1, "R3 offset strobe", offset_wr, 1);
        idle(1);
        chk(offset_wr == 1'b0, "R3 strobe ends", offset_wr, 0);
        idle(4);
        chk(empty_n == 1'b0, "R3 no fifo store", empty_n, 0);
        wr(9'h0CD);
        idle(4);
        chk(empty_n == 1'b1, "R3 fifo store", empty_n, 1);
        rd();
        chk(rd_data == 9'h0CD, "R3 stored word", rd_data, 9'h0CD);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule